// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called A and B, and passes words between them in either direction. Each direction has its own storage register and its own capture clock. The A register takes the value on the A bus at every rising edge of its clock. The B register does the same for the B bus on its own clock. A capture happens on every edge, whatever the output enables are set to.

Each direction has its own select. The select decides whether the far bus receives the live word from the near bus or the word held in that direction's register. Each direction also has its own drive enable. The enable towards B is active high, and the enable towards A is active low. With these controls the block can isolate the buses and load either register from its own bus. It can pass data through in real time in one direction. It can copy one bus into both registers by clocking the opposite register while the block drives that bus. It can also drive both buses from storage at once, which exchanges the two stored words.

Each bus is modelled as three separate signals: a sampled input, a driven output and an output enable. The resolution of the shared wire is left to the surroundings. Both registers clear to zero under an asynchronous active-low reset.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_ab` the A register loads `a_in`. On each rising edge of `clk_ba` the B register loads `b_in`.
- R2: A capture happens at every clock edge whatever the enables are set to. While the block drives a bus, clocking the opposite register stores the driven word, so one bus word can be placed in both registers.
- R3: `b_oe` is high exactly when `drv_b_en` is 1. `a_oe` is high exactly when `drv_a_en_n` is 0.
- R4: With `sel_ab` = 0, `b_out` equals the current `a_in`. With `sel_ab` = 1, `b_out` equals the A register.
- R5: With `sel_ba` = 0, `a_out` equals the current `b_in`. With `sel_ba` = 1, `a_out` equals the B register.
- R6: With `drv_b_en` = 0 and `drv_a_en_n` = 1, neither output enable is asserted, and either register or both can still be loaded.
- R7: With `drv_b_en` = 1, `drv_a_en_n` = 0 and both selects at 1, `b_out` carries the A register and `a_out` carries the B register. Clocking both registers together then swaps their contents.
- R8: While `rst_n` is 0, both registers read as zero.
- R9: While a select is 1, a change on the near bus input does not alter the stored output on the far side. That output changes only at its own register's clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| clk_ab | input | 1 | Capture clock of the A register |
| clk_ba | input | 1 | Capture clock of the B register |
| sel_ab | input | 1 | Source towards B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source towards A: 0 live B, 1 stored B |
| drv_b_en | input | 1 | Active-high drive enable for the B bus |
| drv_a_en_n | input | 1 | Active-low drive enable for the A bus |
| a_in | input | W | Word sampled from the A bus |
| a_out | output | W | Word offered to the A bus |
| a_oe | output | 1 | A bus drive enable |
| b_in | input | W | Word sampled from the B bus |
| b_out | output | W | Word offered to the B bus |
| b_oe | output | 1 | B bus drive enable |

## Verification
The bench builds the block at its default width of 8 bits. At that width, patterns such as 0x81, 0xA5/0x5A and 0x3C/0xC3 exercise the edge bits and alternating bits of every lane, in both directions and in the swap. The bench resolves each bus from its own model of the registers. This makes the loopback cases reachable, where a register captures the word this block is itself driving, as well as the simultaneous swap.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_W_DEF = 8;
    localparam int XCVR_DIRS  = 2;

    // Index of each direction in the per-direction arrays.
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

    typedef struct packed {
        logic use_stored;
        logic drive;
    } path_ctrl_t;

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] word;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.word = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.word;

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
    parameter int W = 8
) (
    input  xcvr_pkg::path_ctrl_t ctrl,
    input  logic [W-1:0]         live,
    input  logic [W-1:0]         stored,
    output logic [W-1:0]         out,
    output logic                 oe
);

    always_comb begin
        out = ctrl.use_stored ? stored : live;
        oe  = ctrl.drive;
    end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
    parameter int W = xcvr_pkg::XCVR_W_DEF
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         drv_b_en,
    input  logic         drv_a_en_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    import xcvr_pkg::*;

    localparam int ND = XCVR_DIRS;

    logic [ND-1:0]        dir_clk;
    logic [ND-1:0][W-1:0] dir_src;
    logic [ND-1:0][W-1:0] dir_store;
    logic [ND-1:0][W-1:0] dir_out;
    logic [ND-1:0]        dir_oe;
    path_ctrl_t [ND-1:0]  dir_ctrl;

    // Direction A->B: source A bus, drives B bus, enable active high.
    assign dir_clk[DIR_AB]             = clk_ab;
    assign dir_src[DIR_AB]             = a_in;
    assign dir_ctrl[DIR_AB].use_stored = sel_ab;
    assign dir_ctrl[DIR_AB].drive      = drv_b_en;

    // Direction B->A: source B bus, drives A bus, enable active low.
    assign dir_clk[DIR_BA]             = clk_ba;
    assign dir_src[DIR_BA]             = b_in;
    assign dir_ctrl[DIR_BA].use_stored = sel_ba;
    assign dir_ctrl[DIR_BA].drive      = ~drv_a_en_n;

    for (genvar d = 0; d < ND; d++) begin : g_dir
        xcvr_capture_reg #(.W(W)) cap_i (
            .clk   (dir_clk[d]),
            .rst_n (rst_n),
            .d     (dir_src[d]),
            .q     (dir_store[d])
        );

        xcvr_path #(.W(W)) path_i (
            .ctrl   (dir_ctrl[d]),
            .live   (dir_src[d]),
            .stored (dir_store[d]),
            .out    (dir_out[d]),
            .oe     (dir_oe[d])
        );
    end

    assign b_out = dir_out[DIR_AB];
    assign b_oe  = dir_oe[DIR_AB];
    assign a_out = dir_out[DIR_BA];
    assign a_oe  = dir_oe[DIR_BA];

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int W = 8
) (
    input logic         rst_n,
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         drv_b_en,
    input logic         drv_a_en_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe
);

    logic seen_ab, seen_ba;

    always_ff @(posedge clk_ab or negedge rst_n) begin
        if (!rst_n) seen_ab <= 1'b0;
        else        seen_ab <= 1'b1;
    end

    always_ff @(posedge clk_ba or negedge rst_n) begin
        if (!rst_n) seen_ba <= 1'b0;
        else        seen_ba <= 1'b1;
    end

    // R1 and R4: the stored word towards B is the A bus at the previous A edge.
    p_stored_ab_r4: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (seen_ab && sel_ab) |-> (b_out == $past(a_in)));

    // R1 and R5: the stored word towards A is the B bus at the previous B edge.
    p_stored_ba_r5: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (seen_ba && sel_ba) |-> (a_out == $past(b_in)));

    // R3: enable polarity on both sides.
    p_oe_pol_r3: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (b_oe == drv_b_en) && (a_oe == !drv_a_en_n));

    p_oe_pol_ba_r3: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (b_oe == drv_b_en) && (a_oe == !drv_a_en_n));

    // R8: registers are cleared when reset is released.
    p_clear_ab_r8: assert property (@(posedge rst_n) disable iff (!rst_n)
        sel_ab |-> (b_out == '0));

    p_clear_ba_r8: assert property (@(posedge rst_n) disable iff (!rst_n)
        sel_ba |-> (a_out == '0));

endmodule

bind bus_xcvr_reg xcvr_chk #(.W(W)) chk_i (
    .rst_n      (rst_n),
    .clk_ab     (clk_ab),
    .clk_ba     (clk_ba),
    .sel_ab     (sel_ab),
    .sel_ba     (sel_ba),
    .drv_b_en   (drv_b_en),
    .drv_a_en_n (drv_a_en_n),
    .a_in       (a_in),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_in       (b_in),
    .b_out      (b_out),
    .b_oe       (b_oe)
);

// File: tb/bus_xcvr_reg_tb_top.sv
`timescale 1ns/1ps
module bus_xcvr_reg_tb_top;

    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n, clk_ab, clk_ba, sel_ab, sel_ba, drv_b_en, drv_a_en_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;

    int errors = 0;
    int checks = 0;

    // Bench model of the two stored words and the external bus drivers.
    logic [W-1:0] ma, mb, a_ext, b_ext;

    bus_xcvr_reg #(.W(W)) dut_i (
        .rst_n      (rst_n),
        .clk_ab     (clk_ab),
        .clk_ba     (clk_ba),
        .sel_ab     (sel_ab),
        .sel_ba     (sel_ba),
        .drv_b_en   (drv_b_en),
        .drv_a_en_n (drv_a_en_n),
        .a_in       (a_in),
        .a_out      (a_out),
        .a_oe       (a_oe),
        .b_in       (b_in),
        .b_out      (b_out),
        .b_oe       (b_oe)
    );

    typedef struct packed {
        logic         oeab;
        logic         oeba_n;
        logic         sab;
        logic         sba;
        logic         pab;
        logic         pba;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'hA5, 4'd6}, // R6 isolate, load both (R1)
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h5A, 8'hFF, 4'd6}, // R6 isolate, load A only
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h00, 4'd4}, // R4 live A to B
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h77, 8'h00, 4'd4}, // R4 stored A to B
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3, 4'd5}, // R5 live B to A
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h11, 4'd5}, // R5 stored B to A
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h96, 8'h00, 4'd2}, // R2 A word into both
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h4E, 4'd2}, // R2 B word into both
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h12, 8'h00, 4'd1}, // R1 load A alone
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hE7, 8'h18, 4'd7}, // R7 exchange
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hE7, 8'h18, 4'd7}, // R7 swap by clocking
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'd7}  // R7 swapped contents
    };

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Resolve both buses from the model, drive the block, compare outputs.
    task automatic settle(input string tag);
        logic [W-1:0] a, b;
        logic         aoe, boe;
        boe = drv_b_en;
        aoe = !drv_a_en_n;
        if (boe && !sel_ab) begin
            a = aoe ? mb : a_ext;
            b = a;
        end else begin
            b = boe ? ma : b_ext;
            a = aoe ? (sel_ba ? mb : b) : a_ext;
        end
        a_in = a;
        b_in = b;
        #1;
        check({tag, " R3 b_oe"}, W'(b_oe), W'(boe));
        check({tag, " R3 a_oe"}, W'(a_oe), W'(aoe));
        if (boe) check({tag, " R4 b_out"}, b_out, sel_ab ? ma : a);
        if (aoe) check({tag, " R5 a_out"}, a_out, sel_ba ? mb : b);
    endtask

    task automatic pulse(input logic pab, input logic pba);
        if (pab) ma = a_in;
        if (pba) mb = b_in;
        clk_ab = pab;
        clk_ba = pba;
        #2;
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        #1;
    endtask

    initial begin
        #(100000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0;
        sel_ab = 1'b1; sel_ba = 1'b1; drv_b_en = 1'b1; drv_a_en_n = 1'b0;
        a_ext = 8'hFF; b_ext = 8'hFF; ma = '0; mb = '0;
        a_in = '0; b_in = '0;
        // R8: reset state, both stored words read zero on the driven outputs.
        repeat (2) @(negedge clk);
        settle("reset R8");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            @(negedge clk);
            tag        = $sformatf("vec%0d R%0d", i, VEC[i].req);
            drv_b_en   = VEC[i].oeab;
            drv_a_en_n = VEC[i].oeba_n;
            sel_ab     = VEC[i].sab;
            sel_ba     = VEC[i].sba;
            a_ext      = VEC[i].a;
            b_ext      = VEC[i].b;
            settle(tag);
            pulse(VEC[i].pab, VEC[i].pba);
            settle(tag);
        end

        // R9: stored output ignores near-bus changes until its own edge.
        @(negedge clk);
        drv_b_en = 1'b1; drv_a_en_n = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        a_ext = 8'h3C; b_ext = 8'h00;
        settle("hold R9");
        pulse(1'b1, 1'b0);
        settle("hold R9");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a_ext = 8'h01 << (2 * k);
            settle("hold R9");
            check("hold R9 b_out", b_out, 8'h3C);
            pulse(1'b0, 1'b1);
            settle("hold R9 other clock");
        end
        pulse(1'b1, 1'b0);
        settle("hold R9 own edge");
        check("hold R9 b_out after edge", b_out, 8'h40);

        // R8: reset in mid-run clears both registers.
        @(negedge clk);
        drv_a_en_n = 1'b0;
        rst_n = 1'b0;
        ma = '0;
        mb = '0;
        settle("mid reset R8");
        check("mid reset R8 a_out", a_out, '0);
        check("mid reset R8 b_out", b_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        settle("after reset R8");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule